// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This unit keeps an interrupt-enable word and an interrupt-status word for each locality of a multi-locality security device. It drives one interrupt line that all localities share. Four kinds of event arrive as single-cycle pulses tagged with a target locality: data-available, status-valid, locality-changed and command-ready. An event is latched into that locality's status only when the locality has both its global enable and the event's own enable set. Software clears status bits by writing ones to them. The line falls when such a write leaves the written locality's status empty.

The unit also answers reads of four fixed registers: capability, interrupt vector, device/vendor identity and revision. Reads of any offset it does not map return all ones. Writes come through a 32-bit register port with byte enables. A write to the enable or status word takes effect only when the writing locality is the one the arbiter reports as active. The unit does not create events and does not arbitrate between localities.

Top module: `ies_unit`

## Requirements
- R1: After reset, every locality's enable word reads 0x0000_0008, which is low-level polarity with every event disabled. Every status word reads zero. The logical line is low and the pin is high.
- R2: An event pulse for locality L sets status bit b only if L's enable word has both bit 31 and bit b set. The event order is evt_req[0] data-available to bit 0, evt_req[1] status-valid to bit 1, evt_req[2] locality-changed to bit 2, and evt_req[3] command-ready to bit 7. Events aimed at a locality number of NUM_LOC or more are dropped.
- R3: A write to the status word (byte offset 0x10) clears each status bit whose written data bit is one, but only bits in the supported set 0x87 and only in enabled byte lanes. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: The line rises in the cycle after any event is latched. It falls only after an accepted status write leaves that locality's status at zero, and only if no event latches in the same cycle.
- R5: Writes to the enable and status words have no effect unless act_valid is high and act_loc equals the locality field bus_addr[14:12].
- R6: A write to the enable word (byte offset 0x08) replaces only the enabled byte lanes. It stores only bit 31, polarity bits 4:3 and event bits 0, 1, 2 and 7, so the stored word is always within mask 0x8000_009F.
- R7: The vector word (offset 0x0C) always reads VECTOR. Writes to it change nothing.
- R8: The capability word (offset 0x14) reads 0x2000_0697. That value is version code 2 in bits 31:28, transfer-size code 3 in bits 10:9, bit 8 clear for a dynamic burst count, bit 4 for low-level support, and the supported event bits.
- R9: Offset 0xF00 reads {DEV_ID, VEN_ID} and offset 0xF04 reads REV_ID zero-extended. Any other offset, and any locality field of NUM_LOC or more, reads 0xFFFF_FFFF.
- R10: irq_pin is the line level registered one more cycle. It is inverted when bit 3 of the active locality's enable word is set, and also when no valid locality is active.
- R11: A read request produces bus_rvalid with bus_rdata exactly one cycle later, sampled from the state before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Locality in bits 14:12, byte offset in 11:0 |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| act_valid | input | 1 | A locality is active |
| act_loc | input | 3 | Active locality number |
| evt_req | input | 4 | Event pulses (data-avail, sts-valid, loc-changed, cmd-ready) |
| evt_loc | input | 3 | Target locality of the event pulses |
| irq_line | output | 1 | Logical interrupt state, active high |
| irq_pin | output | 1 | Physical line after polarity |

## Verification
Events are sent with global enables off and individual enables on, and with both on. This shows whether the gate is a true AND of the two enables. Partial clears, clears that mix in unsupported bits, and a clear that coincides with a set on the same bit show how the line decides to fall and which operation has priority. Writes are sent from a non-active locality and while no locality is active, and byte-lane enable writes and the polarity switch are exercised. A long stretch of random traffic over all offsets and localities is then compared cycle by cycle with a behavioural model.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int WORD_W = 32;
  localparam int EVT_N  = 4;

  localparam logic [WORD_W-1:0] EVT_BITS  = 32'h0000_0087;
  localparam logic [WORD_W-1:0] EN_KEEP   = 32'h8000_0018 | EVT_BITS;
  localparam logic [WORD_W-1:0] EN_RESET  = 32'h0000_0008;
  localparam logic [WORD_W-1:0] CAP_VALUE = 32'h2000_0610 | EVT_BITS;

  localparam logic [9:0] W_EN  = 10'h002;
  localparam logic [9:0] W_VEC = 10'h003;
  localparam logic [9:0] W_ST  = 10'h004;
  localparam logic [9:0] W_CAP = 10'h005;
  localparam logic [9:0] W_ID  = 10'h3C0;
  localparam logic [9:0] W_REV = 10'h3C1;

  function automatic logic [WORD_W-1:0] evt_to_bits(input logic [EVT_N-1:0] e);
    logic [WORD_W-1:0] r;
    r = '0;
    r[0] = e[0];
    r[1] = e[1];
    r[2] = e[2];
    r[7] = e[3];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] lanes_to_mask(input logic [3:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/ies_loc_regs.sv
module ies_loc_regs
  import ies_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              st_we,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic              evt_hit,
  input  logic [WORD_W-1:0] evt_bits,
  output logic [WORD_W-1:0] inte,
  output logic [WORD_W-1:0] ints,
  output logic              latched,
  output logic              st_zero_next
);
  logic [WORD_W-1:0] inte_q, ints_q, set_w, clr_w, ints_d;

  assign set_w  = (evt_hit && inte_q[31]) ? (evt_bits & inte_q & EVT_BITS) : '0;
  assign clr_w  = st_we ? (wdata & wmask & EVT_BITS) : '0;
  assign ints_d = (ints_q & ~clr_w) | set_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      inte_q <= EN_RESET;
      ints_q <= '0;
    end else begin
      if (en_we) inte_q <= (inte_q & ~wmask) | (wdata & wmask & EN_KEEP);
      ints_q <= ints_d;
    end
  end

  assign inte         = inte_q;
  assign ints         = ints_q;
  assign latched      = |set_w;
  assign st_zero_next = (ints_d == '0);

  AST_NO_LATCH_WITHOUT_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    !inte_q[31] |=> ((ints_q & ~$past(ints_q)) == '0)); // R2
  AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(inte_q)); // R5
endmodule

// File: rtl/ies_line.sv
module ies_line (
  input  logic clk,
  input  logic rst,
  input  logic any_latch,
  input  logic drop_req,
  input  logic pol_low,
  output logic irq_line,
  output logic irq_pin
);
  logic irq_q, pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      if (any_latch)     irq_q <= 1'b1;
      else if (drop_req) irq_q <= 1'b0;
      pin_q <= pol_low ? ~irq_q : irq_q;
    end
  end

  assign irq_line = irq_q;
  assign irq_pin  = pin_q;

  AST_RISE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(any_latch)); // R4
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(drop_req)); // R4
endmodule

// File: rtl/ies_rd_mux.sv
module ies_rd_mux
  import ies_pkg::*;
#(
  parameter int              NUM_LOC = 5,
  parameter int              LOC_W   = 3,
  parameter int              WIDX_W  = 10,
  parameter logic [WORD_W-1:0] VECTOR = 32'd5,
  parameter logic [15:0]     DEV_ID  = 16'h0001,
  parameter logic [15:0]     VEN_ID  = 16'h5A17,
  parameter logic [7:0]      REV_ID  = 8'h01
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_req,
  input  logic                           loc_ok,
  input  logic [LOC_W-1:0]               loc_idx,
  input  logic [WIDX_W-1:0]              word,
  input  logic [NUM_LOC-1:0][WORD_W-1:0] inte_all,
  input  logic [NUM_LOC-1:0][WORD_W-1:0] ints_all,
  output logic [WORD_W-1:0]              rdata,
  output logic                           rvalid
);
  logic [WORD_W-1:0] val, rdata_q;
  logic              rvalid_q;

  always_comb begin
    val = '1;
    if (loc_ok) begin
      if      (word == WIDX_W'(W_EN))  val = inte_all[loc_idx];
      else if (word == WIDX_W'(W_ST))  val = ints_all[loc_idx];
      else if (word == WIDX_W'(W_VEC)) val = VECTOR;
      else if (word == WIDX_W'(W_CAP)) val = CAP_VALUE;
      else if (word == WIDX_W'(W_ID))  val = {DEV_ID, VEN_ID};
      else if (word == WIDX_W'(W_REV)) val = {24'h0, REV_ID};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= val;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rvalid_q |-> $past(rd_req)); // R11
endmodule

// File: rtl/ies_unit.sv
module ies_unit
  import ies_pkg::*;
#(
  parameter int              NUM_LOC = 5,
  parameter int              LOC_W   = 3,
  parameter int              OFF_W   = 12,
  parameter logic [31:0]     VECTOR  = 32'd5,
  parameter logic [15:0]     DEV_ID  = 16'h0001,
  parameter logic [15:0]     VEN_ID  = 16'h5A17,
  parameter logic [7:0]      REV_ID  = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [LOC_W+OFF_W-1:0]   bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic                     act_valid,
  input  logic [LOC_W-1:0]         act_loc,
  input  logic [3:0]               evt_req,
  input  logic [LOC_W-1:0]         evt_loc,
  output logic                     irq_line,
  output logic                     irq_pin
);
  localparam int ADDR_W = LOC_W + OFF_W;
  localparam int WIDX_W = OFF_W - 2;
  localparam logic [LOC_W-1:0] LOC_LAST = LOC_W'(NUM_LOC - 1);

  logic [LOC_W-1:0]  bus_loc;
  logic [WIDX_W-1:0] word;
  logic              loc_ok, is_owner, wr_ok, evt_any, act_ok;
  logic [WORD_W-1:0] wmask, ebits;
  logic [NUM_LOC-1:0] en_we_v, st_we_v, hit_v, latch_v, zero_v;
  logic [NUM_LOC-1:0][WORD_W-1:0] inte_all, ints_all;
  logic              any_latch, drop_req, pol_low;

  assign bus_loc  = bus_addr[ADDR_W-1:OFF_W];
  assign word     = bus_addr[OFF_W-1:2];
  assign loc_ok   = (bus_loc <= LOC_LAST);
  assign act_ok   = act_valid && (act_loc <= LOC_LAST);
  assign is_owner = act_ok && (act_loc == bus_loc);
  assign wr_ok    = bus_req && bus_we && is_owner;
  assign wmask    = lanes_to_mask(bus_be);
  assign evt_any  = |evt_req;
  assign ebits    = evt_to_bits(evt_req);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    assign en_we_v[i] = wr_ok && (word == WIDX_W'(W_EN)) && (bus_loc == LOC_W'(i));
    assign st_we_v[i] = wr_ok && (word == WIDX_W'(W_ST)) && (bus_loc == LOC_W'(i));
    assign hit_v[i]   = evt_any && (evt_loc == LOC_W'(i));

    ies_loc_regs u_regs (
      .clk          (clk),
      .rst          (rst),
      .en_we        (en_we_v[i]),
      .st_we        (st_we_v[i]),
      .wmask        (wmask),
      .wdata        (bus_wdata),
      .evt_hit      (hit_v[i]),
      .evt_bits     (ebits),
      .inte         (inte_all[i]),
      .ints         (ints_all[i]),
      .latched      (latch_v[i]),
      .st_zero_next (zero_v[i])
    );
  end

  assign any_latch = |latch_v;
  assign drop_req  = |(st_we_v & zero_v);
  assign pol_low   = act_ok ? inte_all[act_loc][3] : 1'b1;

  ies_line u_line (
    .clk       (clk),
    .rst       (rst),
    .any_latch (any_latch),
    .drop_req  (drop_req),
    .pol_low   (pol_low),
    .irq_line  (irq_line),
    .irq_pin   (irq_pin)
  );

  ies_rd_mux #(
    .NUM_LOC (NUM_LOC),
    .LOC_W   (LOC_W),
    .WIDX_W  (WIDX_W),
    .VECTOR  (VECTOR),
    .DEV_ID  (DEV_ID),
    .VEN_ID  (VEN_ID),
    .REV_ID  (REV_ID)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (bus_req && !bus_we),
    .loc_ok   (loc_ok),
    .loc_idx  (bus_loc),
    .word     (word),
    .inte_all (inte_all),
    .ints_all (ints_all),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  AST_FOREIGN_WRITE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !is_owner) |=> $stable(inte_all)); // R5
endmodule

// File: tb/ies_unit_test.sv
module ies_unit_test;
  localparam int NL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 0, bus_we = 0;
  logic [14:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        act_valid = 0;
  logic [2:0]  act_loc = '0;
  logic [3:0]  evt_req = '0;
  logic [2:0]  evt_loc = '0;
  logic        irq_line, irq_pin;

  ies_unit uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .act_valid(act_valid), .act_loc(act_loc), .evt_req(evt_req), .evt_loc(evt_loc),
    .irq_line(irq_line), .irq_pin(irq_pin)
  );

  always #5 clk = ~clk;

  int    checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [31:0] m_inte [NL];
  logic [31:0] m_ints [NL];
  logic        m_irq, m_pin, m_rv;
  logic [31:0] m_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [14:0] a);
    int lc;
    int w;
    lc = int'(a[14:12]);
    w  = int'(a[11:2]);
    if (lc >= NL) return 32'hFFFF_FFFF;
    case (w)
      2:      return m_inte[lc];
      3:      return 32'd5;
      4:      return m_ints[lc];
      5:      return 32'h2000_0697;
      'h3C0:  return 32'h0001_5A17;
      'h3C1:  return 32'h0000_0001;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin m_inte[i] = 32'h8; m_ints[i] = 0; end
      m_irq = 0; m_pin = 1; m_rv = 0; m_rd = 0;
    end else begin
      logic        pl, own, anyset, drop;
      int          bl, w;
      logic [31:0] mask, ev, sb, clr, nx;
      pl = (act_valid && act_loc < NL) ? m_inte[act_loc][3] : 1'b1;
      m_pin = pl ? !m_irq : m_irq;
      m_rv = bus_req && !bus_we;
      if (m_rv) m_rd = ref_read(bus_addr);
      bl = int'(bus_addr[14:12]);
      w  = int'(bus_addr[11:2]);
      mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
      own = bus_req && bus_we && act_valid && (int'(act_loc) == bl) && (bl < NL);
      ev = {24'h0, evt_req[3], 4'h0, evt_req[2:0]};
      anyset = 0; drop = 0;
      for (int i = 0; i < NL; i++) begin
        sb = 0; clr = 0;
        if (evt_req != 0 && int'(evt_loc) == i && m_inte[i][31]) sb = ev & m_inte[i];
        if (own && w == 4 && bl == i) clr = bus_wdata & mask & 32'h87;
        nx = (m_ints[i] & ~clr) | sb;
        if (sb != 0) anyset = 1;
        if (own && w == 4 && bl == i && nx == 0) drop = 1;
        m_ints[i] = nx;
      end
      if (own && w == 2)
        m_inte[bl] = (m_inte[bl] & ~mask) | (bus_wdata & mask & 32'h8000_009F);
      if (anyset) m_irq = 1;
      else if (drop) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 rvalid", {31'h0, bus_rvalid}, {31'h0, m_rv});
      if (m_rv) chk({cur_tag, " rdata"}, bus_rdata, m_rd);
      chk("R4 line", {31'h0, irq_line}, {31'h0, m_irq});
      chk("R10 pin", {31'h0, irq_pin}, {31'h0, m_pin});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [14:0] adr(input int lc, input int off);
    return {3'(lc), 12'(off)};
  endfunction

  task automatic cyc(input logic r, input logic we, input logic [14:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [3:0] ev, input logic [2:0] el);
    @(negedge clk);
    bus_req = r; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    evt_req = ev; evt_loc = el;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, '0, '0, '0);
  endtask
  task automatic wr(input int lc, input int off, input logic [31:0] d, input logic [3:0] be);
    cyc(1, 1, adr(lc, off), be, d, '0, '0);
  endtask
  task automatic rd(input int lc, input int off);
    cyc(1, 0, adr(lc, off), '0, '0, '0, '0);
  endtask
  task automatic evt(input logic [3:0] e, input int lc);
    cyc(0, 0, '0, '0, '0, e, 3'(lc));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    for (int i = 0; i < NL; i++) begin rd(i, 'h08); rd(i, 'h10); end
    cur_tag = "R8"; rd(0, 'h14); rd(3, 'h14);
    cur_tag = "R9";
    rd(0, 'hF00); rd(2, 'hF04); rd(0, 'h000); rd(0, 'h018); rd(1, 'h080);
    rd(6, 'h08); rd(7, 'h10); rd(5, 'h14);
    cur_tag = "R2"; evt(4'hF, 1); idle(1); rd(1, 'h10);
    cur_tag = "R5";
    wr(0, 'h08, 32'h8000_0087, 4'hF); idle(1); rd(0, 'h08);
    act_valid = 1; act_loc = 0;
    wr(1, 'h08, 32'h8000_0087, 4'hF); idle(1); rd(1, 'h08);
    cur_tag = "R6";
    wr(0, 'h08, 32'hFFFF_FFFF, 4'hF); rd(0, 'h08);
    wr(0, 'h08, 32'h0000_0000, 4'h1); rd(0, 'h08);
    wr(0, 'h08, 32'h8000_008F, 4'hF); rd(0, 'h08);
    cur_tag = "R2"; evt(4'h1, 0); idle(2); evt(4'h4, 0); rd(0, 'h10); idle(2);
    cur_tag = "R10"; wr(0, 'h08, 32'h8000_0087, 4'hF); idle(3);
    wr(0, 'h08, 32'h8000_008F, 4'hF); idle(3);
    cur_tag = "R3"; wr(0, 'h10, 32'hFFFF_FF01, 4'hF); rd(0, 'h10); idle(2);
    wr(0, 'h10, 32'h0000_0004, 4'h2); rd(0, 'h10);
    wr(0, 'h10, 32'h0000_0004, 4'h1); rd(0, 'h10); idle(2);
    cyc(1, 1, adr(0, 'h10), 4'hF, 32'h0000_0080, 4'h8, 3'd0); rd(0, 'h10); idle(2);
    cur_tag = "R5"; act_loc = 2; wr(0, 'h10, 32'hFF, 4'hF); rd(0, 'h10); idle(1);
    act_valid = 0; wr(2, 'h10, 32'hFF, 4'hF); idle(2);
    act_valid = 1; act_loc = 0; wr(0, 'h10, 32'hFF, 4'hF); rd(0, 'h10); idle(2);
    cur_tag = "R2"; act_loc = 2; wr(2, 'h08, 32'h0000_0087, 4'hF); evt(4'h1, 2); idle(1); rd(2, 'h10);
    evt(4'hF, 5); evt(4'hF, 7); idle(2); rd(0, 'h10);
    cur_tag = "R7"; act_loc = 0; wr(0, 'h0C, 32'hFFFF_FFFF, 4'hF); rd(0, 'h0C); idle(2);
    cur_tag = "R2";
    for (int k = 0; k < 600; k++) begin
      int wsel;
      logic [11:0] off;
      wsel = int'($urandom_range(0, 6));
      case (wsel)
        0: off = 12'h008; 1: off = 12'h010; 2: off = 12'h00C; 3: off = 12'h014;
        4: off = 12'hF00; 5: off = 12'h010; default: off = 12'h008;
      endcase
      if ($urandom_range(0, 15) == 0) begin
        act_valid = ($urandom_range(0, 5) != 0);
        act_loc   = 3'($urandom_range(0, 5));
      end
      cyc(($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)),
          {3'($urandom_range(0, 5)), off}, 4'($urandom_range(0, 15)), $urandom,
          ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0,
          3'($urandom_range(0, 5)));
    end
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule